// File: doc/BRIEF.md
# Indexed Register Access Window

This block lets a host reach a 256-entry byte register space through a window of only eight byte offsets. The host first writes a register number into an internal pointer. It then reads or writes the register that the pointer selects through the data offsets. Two of those offsets advance the pointer after each access, so a run of consecutive registers needs only one pointer load. The host can read the pointer back.

On the far side the block drives a simple synchronous register bus. Each access there is a one-cycle request that the attached controller completes with an acknowledge. A host access that needs the register bus keeps the block busy until that acknowledge arrives.

A write to offset 0 holds the attached controller in reset for a fixed number of cycles. While the controller is still coming out of reset, bit 7 of one of its registers reads as 1. The host selects that register and polls it through the plain read offset until the bit clears. The block passes that bit through unchanged.

Top module: `idx_reg_window`

## Requirements
- R1: Only four host accesses reach the register bus: a read at offset 2 or 3, or a write at offset 6 or 7. Each of these raises `dev_req` exactly once, in the cycle after acceptance, with `dev_addr` equal to the pointer. No other host access raises `dev_req`.
- R2: A write to offset 1 loads the pointer with the written byte.
- R3: A read at offset 2 returns the byte that the register bus returned for the pointed-to register. The pointer is left unchanged.
- R4: A read at offset 3 returns the pointed-to register and then adds one to the pointer. The pointer wraps from 0xFF to 0x00.
- R5: A read at offset 5 returns the pointer value held when the access was accepted. The pointer is left unchanged.
- R6: A write to offset 6 stores the byte into the pointed-to register. The pointer is left unchanged.
- R7: A write to offset 7 stores the byte into the pointed-to register and then adds one to the pointer. The pointer wraps from 0xFF to 0x00.
- R8: A write of any value to offset 0 drives `dev_rst_n` low for exactly RST_CYCLES cycles, starting in the cycle after acceptance. It raises no bus request.
- R9: Register data returned through offset 2 is not masked. While the controller reports reset-busy in bit 7 of its status register, a host poll sees bit 7 set. Once the controller clears the bit, the poll sees it clear, and the pointer stays on the status register throughout.
- R10: A read at offset 0, 1, 4, 6 or 7 returns 0x00. A write at offset 2, 3, 4 or 5 changes neither the pointer nor any register and raises no bus request.
- R11: A host request is taken only while `host_busy` is low. An access that uses the register bus raises `host_ack` in the cycle after `dev_ack`, and its pointer increment lands on that same edge. Any other access raises `host_ack` in the cycle after acceptance. The pointer does not move while an access waits.
- R12: After reset the pointer is 0x00, `dev_rst_n` is high, and `host_busy`, `host_ack` and `dev_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_req | input | 1 | One-cycle host access strobe, taken while host_busy is low |
| host_we | input | 1 | 1 = host write, 0 = host read |
| host_off | input | 3 | Window offset selecting the function |
| host_wdata | input | DW | Host write byte |
| host_busy | output | 1 | A register bus access is in progress |
| host_ack | output | 1 | One-cycle completion pulse for the host access |
| host_rdata | output | DW | Read result, valid with host_ack |
| dev_req | output | 1 | One-cycle register bus request |
| dev_we | output | 1 | Register bus write qualifier |
| dev_addr | output | AW | Register bus address, equal to the pointer |
| dev_wdata | output | DW | Register bus write byte |
| dev_rdata | input | DW | Register bus read byte, sampled with dev_ack |
| dev_ack | input | 1 | Register bus completion |
| dev_rst_n | output | 1 | Active-low reset pulse to the attached controller |

## Verification
Some rules are checked on every cycle. A request on the register bus lasts one cycle, and the pointer holds still while an access is outstanding. The pointer moves by exactly one on completion of an incrementing access. Loads, readback and the zero result from unused reads take effect in the cycle after acceptance, and every reset pulse has the exact length. What only the bench scenarios can show is the data path end to end. That covers:
- bursts that land in consecutive registers and read back in order;
- wrap of the pointer at 0xFF;
- unused writes that leave both the pointer and the register contents intact;
- a host poll that first sees the reset-busy bit set and later sees it cleared, against a controller model that acknowledges with varying delay.

// File: rtl/idxwin_pkg.sv
package idxwin_pkg;

  localparam logic [2:0] OFF_RST    = 3'd0;
  localparam logic [2:0] OFF_PTR_LD = 3'd1;
  localparam logic [2:0] OFF_RD     = 3'd2;
  localparam logic [2:0] OFF_RD_INC = 3'd3;
  localparam logic [2:0] OFF_PTR_RD = 3'd5;
  localparam logic [2:0] OFF_WR     = 3'd6;
  localparam logic [2:0] OFF_WR_INC = 3'd7;

  typedef struct packed {
    logic dev_acc;
    logic dev_wr;
    logic inc;
    logic ptr_ld;
    logic ptr_rd;
    logic rst;
  } op_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } st_e;

endpackage

// File: rtl/idxwin_rst_sync.sv
module idxwin_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];

endmodule

// File: rtl/idxwin_decode.sv
module idxwin_decode
  import idxwin_pkg::*;
(
  input  logic       valid,
  input  logic       we,
  input  logic [2:0] off,
  output op_t        op
);

  always_comb begin
    op = '0;
    if (valid) begin
      case (off)
        OFF_RST:    op.rst    = we;
        OFF_PTR_LD: op.ptr_ld = we;
        OFF_RD:     op.dev_acc = !we;
        OFF_RD_INC: begin
          op.dev_acc = !we;
          op.inc     = !we;
        end
        OFF_PTR_RD: op.ptr_rd = !we;
        OFF_WR: begin
          op.dev_acc = we;
          op.dev_wr  = we;
        end
        OFF_WR_INC: begin
          op.dev_acc = we;
          op.dev_wr  = we;
          op.inc     = we;
        end
        default: op = '0;
      endcase
    end
  end

endmodule

// File: rtl/idxwin_ptr.sv
module idxwin_ptr #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_sn,
  input  logic          ld,
  input  logic [AW-1:0] ld_val,
  input  logic          inc,
  output logic [AW-1:0] ptr
);

  logic [AW-1:0] ptr_q, ptr_d;
  logic          ptr_en;

  always_comb begin
    ptr_en = ld | inc;
    if (ld)       ptr_d = ld_val;
    else if (inc) ptr_d = ptr_q + 1'b1;
    else          ptr_d = ptr_q;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)     ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

endmodule

// File: rtl/idxwin_rstgen.sv
module idxwin_rstgen #(
  parameter int RST_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_sn,
  input  logic start,
  output logic dev_rst_n
);

  localparam int CW = $clog2(RST_CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = start | (cnt_q != '0);
    if (start) cnt_d = CW'(RST_CYCLES);
    else       cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign dev_rst_n = (cnt_q == '0);

endmodule

// File: rtl/idx_reg_window.sv
module idx_reg_window
  import idxwin_pkg::*;
#(
  parameter int AW         = 8,
  parameter int DW         = 8,
  parameter int RST_CYCLES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_req,
  input  logic          host_we,
  input  logic [2:0]    host_off,
  input  logic [DW-1:0] host_wdata,
  output logic          host_busy,
  output logic          host_ack,
  output logic [DW-1:0] host_rdata,
  output logic          dev_req,
  output logic          dev_we,
  output logic [AW-1:0] dev_addr,
  output logic [DW-1:0] dev_wdata,
  input  logic [DW-1:0] dev_rdata,
  input  logic          dev_ack,
  output logic          dev_rst_n
);

  logic          rst_sn;
  logic          accept;
  op_t           op;
  logic [AW-1:0] ptr;
  logic          ptr_inc;

  st_e           state_q, state_d;
  logic          wr_q, inc_q;
  logic [DW-1:0] wdata_q;
  logic          cap_en;
  logic          ack_q, ack_d;
  logic [DW-1:0] rdata_q, rdata_d;

  idxwin_rst_sync u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  assign accept = host_req && (state_q == ST_IDLE);

  idxwin_decode u_dec (
    .valid (accept),
    .we    (host_we),
    .off   (host_off),
    .op    (op)
  );

  idxwin_ptr #(.AW(AW)) u_ptr (
    .clk    (clk),
    .rst_sn (rst_sn),
    .ld     (op.ptr_ld),
    .ld_val (AW'(host_wdata)),
    .inc    (ptr_inc),
    .ptr    (ptr)
  );

  idxwin_rstgen #(.RST_CYCLES(RST_CYCLES)) u_rstgen (
    .clk       (clk),
    .rst_sn    (rst_sn),
    .start     (op.rst),
    .dev_rst_n (dev_rst_n)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    ack_d   = 1'b0;
    rdata_d = rdata_q;
    ptr_inc = 1'b0;
    cap_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (op.dev_acc) begin
            state_d = ST_REQ;
            cap_en  = 1'b1;
          end else begin
            ack_d   = 1'b1;
            rdata_d = op.ptr_rd ? DW'(ptr) : '0;
          end
        end
      end
      ST_REQ, ST_WAIT: begin
        if (dev_ack) begin
          state_d = ST_IDLE;
          ack_d   = 1'b1;
          rdata_d = wr_q ? '0 : dev_rdata;
          ptr_inc = inc_q;
        end else begin
          state_d = ST_WAIT;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= ST_IDLE;
      ack_q   <= 1'b0;
      rdata_q <= '0;
      wr_q    <= 1'b0;
      inc_q   <= 1'b0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      ack_q   <= ack_d;
      if (ack_d) rdata_q <= rdata_d;
      if (cap_en) begin
        wr_q    <= op.dev_wr;
        inc_q   <= op.inc;
        wdata_q <= host_wdata;
      end
    end
  end

  assign host_busy  = (state_q != ST_IDLE);
  assign host_ack   = ack_q;
  assign host_rdata = rdata_q;
  assign dev_req    = (state_q == ST_REQ);
  assign dev_we     = wr_q;
  assign dev_addr   = ptr;
  assign dev_wdata  = wdata_q;

endmodule

// File: rtl/idxwin_chk.sv
module idxwin_chk #(
  parameter int AW         = 8,
  parameter int DW         = 8,
  parameter int RST_CYCLES = 16
) (
  input logic          clk,
  input logic          rst_sn,
  input logic          host_req,
  input logic          host_we,
  input logic [2:0]    host_off,
  input logic [DW-1:0] host_wdata,
  input logic          host_busy,
  input logic          host_ack,
  input logic [DW-1:0] host_rdata,
  input logic          dev_req,
  input logic          dev_ack,
  input logic          dev_rst_n,
  input logic [AW-1:0] ptr
);

  logic acc_c, devop_c, incop_c, unused_rd_c;
  logic pend_inc_q;
  int   low_cnt_q;

  always_comb begin
    acc_c       = host_req && !host_busy;
    devop_c     = (!host_we && (host_off == 3'd2 || host_off == 3'd3)) ||
                  ( host_we && (host_off == 3'd6 || host_off == 3'd7));
    incop_c     = (!host_we && host_off == 3'd3) || (host_we && host_off == 3'd7);
    unused_rd_c = !host_we && (host_off == 3'd0 || host_off == 3'd1 ||
                  host_off == 3'd4 || host_off == 3'd6 || host_off == 3'd7);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      pend_inc_q <= 1'b0;
      low_cnt_q  <= 0;
    end else begin
      if (acc_c) pend_inc_q <= incop_c;
      if (acc_c && host_we && host_off == 3'd0) low_cnt_q <= 0;
      else if (!dev_rst_n)                      low_cnt_q <= low_cnt_q + 1;
      else                                      low_cnt_q <= 0;
    end
  end

  AST_DEV_REQ_NEXT: assert property (@(posedge clk) disable iff (!rst_sn)
    acc_c && devop_c |=> dev_req);                                        // R1
  AST_LOCAL_NO_DEV_REQ: assert property (@(posedge clk) disable iff (!rst_sn)
    acc_c && !devop_c |=> !dev_req);                                      // R1
  AST_LOAD_PTR: assert property (@(posedge clk) disable iff (!rst_sn)
    acc_c && host_we && host_off == 3'd1 |=> ptr == AW'($past(host_wdata))); // R2
  AST_PTR_HOLD_DONE: assert property (@(posedge clk) disable iff (!rst_sn)
    host_busy && dev_ack && !pend_inc_q |=> $stable(ptr));                // R3
  AST_PTR_INC_DONE: assert property (@(posedge clk) disable iff (!rst_sn)
    host_busy && dev_ack && pend_inc_q |=> ptr == AW'($past(ptr) + 1'b1)); // R4
  AST_PTR_READBACK: assert property (@(posedge clk) disable iff (!rst_sn)
    acc_c && !host_we && host_off == 3'd5 |=> $stable(ptr) && host_rdata == DW'($past(ptr))); // R5
  AST_RST_START: assert property (@(posedge clk) disable iff (!rst_sn)
    acc_c && host_we && host_off == 3'd0 |=> !dev_rst_n);                 // R8
  AST_RST_LEN: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(dev_rst_n) |-> low_cnt_q == RST_CYCLES);                       // R8
  AST_UNUSED_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_sn)
    acc_c && unused_rd_c |=> host_ack && host_rdata == '0);               // R10
  AST_LOCAL_ACK: assert property (@(posedge clk) disable iff (!rst_sn)
    acc_c && !devop_c |=> host_ack);                                      // R11
  AST_DEV_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_sn)
    dev_req |=> !dev_req);                                                // R11
  AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rst_sn)
    host_busy |-> !host_ack);                                             // R11
  AST_PTR_STALL: assert property (@(posedge clk) disable iff (!rst_sn)
    host_busy && !dev_ack |=> $stable(ptr));                              // R11

endmodule

bind idx_reg_window idxwin_chk #(.AW(AW), .DW(DW), .RST_CYCLES(RST_CYCLES)) u_chk (
  .clk        (clk),
  .rst_sn     (rst_sn),
  .host_req   (host_req),
  .host_we    (host_we),
  .host_off   (host_off),
  .host_wdata (host_wdata),
  .host_busy  (host_busy),
  .host_ack   (host_ack),
  .host_rdata (host_rdata),
  .dev_req    (dev_req),
  .dev_ack    (dev_ack),
  .dev_rst_n  (dev_rst_n),
  .ptr        (ptr)
);

// File: tb/tb_idx_reg_window.sv
module tb_idx_reg_window;

  localparam int AW   = 8;
  localparam int DW   = 8;
  localparam int RSTC = 16;
  localparam logic [7:0] STAT_REG = 8'h02;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          host_req, host_we;
  logic [2:0]    host_off;
  logic [DW-1:0] host_wdata;
  logic          host_busy, host_ack;
  logic [DW-1:0] host_rdata;
  logic          dev_req, dev_we;
  logic [AW-1:0] dev_addr;
  logic [DW-1:0] dev_wdata;
  logic [DW-1:0] dev_rdata;
  logic          dev_ack;
  logic          dev_rst_n;

  always #10 clk = ~clk;

  idx_reg_window #(.AW(AW), .DW(DW), .RST_CYCLES(RSTC)) dut (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_off(host_off), .host_wdata(host_wdata), .host_busy(host_busy),
    .host_ack(host_ack), .host_rdata(host_rdata), .dev_req(dev_req),
    .dev_we(dev_we), .dev_addr(dev_addr), .dev_wdata(dev_wdata),
    .dev_rdata(dev_rdata), .dev_ack(dev_ack), .dev_rst_n(dev_rst_n)
  );

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  bit done = 0;
  bit mon_on = 0;

  logic [7:0] mem [256];
  int mptr = 0;
  int mrst = 0;
  int dev_reqs = 0;
  int ack_cyc = 0;
  int stat_cnt = 0;
  int lat_idx = 0;
  int wt = 0;
  bit pend = 0;
  logic [7:0] last_resp = 8'h00;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input int act, input int expv, input string what);
    vectors++;
    if (act != expv) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  // controller model: varied acknowledge delay, reset-busy status bit
  always @(posedge clk) begin
    #5;
    dev_ack = 1'b0;
    if (!dev_rst_n)        stat_cnt = 5;
    else if (stat_cnt > 0) stat_cnt--;
    if (dev_req) begin
      dev_reqs++;
      chk("R1", int'(dev_addr), mptr, "bus address vs pointer");
      pend = 1;
      wt = lat_idx % 4;
      lat_idx++;
    end
    if (pend) begin
      if (wt == 0) begin
        dev_ack = 1'b1;
        ack_cyc = cyc;
        if (dev_we) mem[dev_addr] = dev_wdata;
        last_resp = mem[dev_addr];
        if (dev_addr == STAT_REG && (stat_cnt > 0 || !dev_rst_n)) last_resp = last_resp | 8'h80;
        dev_rdata = last_resp;
        pend = 0;
      end else begin
        wt--;
      end
    end
  end

  // per-clock reference of the reset pulse
  always @(negedge clk) begin
    if (mon_on) begin
      chk("R8", int'(dev_rst_n), (mrst == 0) ? 1 : 0, "dev_rst_n vs model");
      if (mrst > 0) mrst--;
      if (host_req && !host_busy && host_we && host_off == 3'd0) mrst = RSTC;
    end
  end

  task automatic acc(input string tag, input bit we, input logic [2:0] off,
                     input logic [7:0] wd, output logic [7:0] rd);
    int start, r0, n;
    bit devop;
    devop = (!we && (off == 3'd2 || off == 3'd3)) || (we && (off == 3'd6 || off == 3'd7));
    @(posedge clk); #5;
    chk("R11", int'(host_busy), 0, "busy before request");
    host_req = 1'b1; host_we = we; host_off = off; host_wdata = wd;
    start = cyc; r0 = dev_reqs;
    @(posedge clk); #5;
    host_req = 1'b0;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!host_ack && n < 40);
    chk("R11", int'(host_ack), 1, "ack seen");
    rd = host_rdata;
    chk("R1", dev_reqs - r0, devop ? 1 : 0, {tag, " bus requests"});
    if (devop) chk("R11", cyc, ack_cyc + 1, "ack cycle after dev_ack");
    else       chk("R11", cyc, start + 1, "local ack cycle");
    if (we && off == 3'd1) mptr = int'(wd);
    if ((!we && off == 3'd3) || (we && off == 3'd7)) mptr = (mptr + 1) % 256;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
    end
  end

  initial begin
    logic [7:0] rd, v;
    int polls;
    bit seen_set;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h3C;
    rst_n = 1'b0; host_req = 1'b0; host_we = 1'b0; host_off = '0;
    host_wdata = '0; dev_ack = 1'b0; dev_rdata = '0;
    repeat (4) @(posedge clk);
    #5 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R12", int'(host_busy), 0, "busy after reset");
    chk("R12", int'(host_ack), 0, "ack after reset");
    chk("R12", int'(dev_req), 0, "dev_req after reset");
    chk("R12", int'(dev_rst_n), 1, "dev_rst_n after reset");
    mon_on = 1;
    acc("R12", 0, 3'd5, 8'h00, rd);
    chk("R12", int'(rd), 0, "pointer after reset");

    // load and read back
    acc("R2", 1, 3'd1, 8'h10, rd);
    acc("R5", 0, 3'd5, 8'h00, rd);
    chk("R2", int'(rd), 8'h10, "loaded pointer");
    // plain write then plain read
    acc("R6", 1, 3'd6, 8'hA5, rd);
    acc("R5", 0, 3'd5, 8'h00, rd);
    chk("R6", int'(rd), 8'h10, "pointer after plain write");
    acc("R3", 0, 3'd2, 8'h00, rd);
    chk("R3", int'(rd), 8'hA5, "plain read data");
    acc("R5", 0, 3'd5, 8'h00, rd);
    chk("R3", int'(rd), 8'h10, "pointer after plain read");

    // incrementing write burst, incrementing read burst
    acc("R2", 1, 3'd1, 8'h20, rd);
    for (int i = 0; i < 4; i++) acc("R7", 1, 3'd7, 8'h11 * 8'(i + 1), rd);
    acc("R5", 0, 3'd5, 8'h00, rd);
    chk("R7", int'(rd), 8'h24, "pointer after write burst");
    acc("R2", 1, 3'd1, 8'h20, rd);
    for (int i = 0; i < 4; i++) begin
      acc("R4", 0, 3'd3, 8'h00, rd);
      chk("R4", int'(rd), 8'h11 * (i + 1), "burst read data");
    end
    acc("R5", 0, 3'd5, 8'h00, rd);
    chk("R4", int'(rd), 8'h24, "pointer after read burst");

    // wrap at the top of the space
    acc("R2", 1, 3'd1, 8'hFF, rd);
    acc("R7", 1, 3'd7, 8'h77, rd);
    acc("R5", 0, 3'd5, 8'h00, rd);
    chk("R7", int'(rd), 8'h00, "write wrap");
    acc("R2", 1, 3'd1, 8'hFF, rd);
    acc("R4", 0, 3'd3, 8'h00, rd);
    chk("R4", int'(rd), 8'h77, "read at 0xFF");
    acc("R5", 0, 3'd5, 8'h00, rd);
    chk("R4", int'(rd), 8'h00, "read wrap");

    // unused offsets
    acc("R10", 1, 3'd1, 8'h40, rd);
    acc("R10", 0, 3'd2, 8'h00, v);
    chk("R10", int'(v), int'(8'h40 ^ 8'h3C), "register before unused writes");
    acc("R10", 1, 3'd2, 8'hFF, rd);
    acc("R10", 1, 3'd3, 8'hFF, rd);
    acc("R10", 1, 3'd4, 8'hFF, rd);
    acc("R10", 1, 3'd5, 8'hFF, rd);
    acc("R10", 0, 3'd5, 8'h00, rd);
    chk("R10", int'(rd), 8'h40, "pointer after unused writes");
    acc("R10", 0, 3'd2, 8'h00, rd);
    chk("R10", int'(rd), int'(v), "register after unused writes");
    acc("R10", 0, 3'd0, 8'h00, rd); chk("R10", int'(rd), 0, "read offset 0");
    acc("R10", 0, 3'd1, 8'h00, rd); chk("R10", int'(rd), 0, "read offset 1");
    acc("R10", 0, 3'd4, 8'h00, rd); chk("R10", int'(rd), 0, "read offset 4");
    acc("R10", 0, 3'd6, 8'h00, rd); chk("R10", int'(rd), 0, "read offset 6");
    acc("R10", 0, 3'd7, 8'h00, rd); chk("R10", int'(rd), 0, "read offset 7");

    // reset strobe and status polling
    acc("R8", 1, 3'd0, 8'h5A, rd);
    chk("R8", int'(dev_rst_n), 0, "reset asserted");
    acc("R9", 1, 3'd1, STAT_REG, rd);
    polls = 0;
    seen_set = 0;
    do begin
      acc("R9", 0, 3'd2, 8'h00, rd);
      chk("R9", int'(rd), int'(last_resp), "poll data");
      if (polls == 0) chk("R9", int'(rd[7]), 1, "busy bit on first poll");
      if (rd[7]) seen_set = 1;
      polls++;
    end while (rd[7] && polls < 60);
    chk("R9", int'(seen_set), 1, "busy bit observed");
    chk("R9", int'(rd[7]), 0, "busy bit cleared");
    acc("R9", 0, 3'd5, 8'h00, rd);
    chk("R9", int'(rd), int'(STAT_REG), "pointer held during poll");
    repeat (4) @(negedge clk);
    chk("R8", int'(dev_rst_n), 1, "reset released");

    done = 1;
    summary();
  end

endmodule